// File: doc/BRIEF.md
# Programmable Periodic Interrupt Divider

This block counts a 32.768 kHz time base, supplied as a one-cycle enable pulse in the system clock domain, through a binary divider chain. It raises a periodic flag at a rate chosen by a 4-bit rate field. The rate field does not map to frequency in a straight line. Code 0 turns the periodic source off. Codes 1 and 2 select the slow 256 Hz and 128 Hz taps. Codes 3 to 15 start at 8.192 kHz and halve the rate at each step, down to 2 Hz.

A 3-bit mode field controls the chain. It can hold the chain at zero, let it run, or put it in a test mode in which every time-base pulse produces a flag. The flag stays set until it is read. It pulls the active-low interrupt line low only while the interrupt enable is set.

Software writes the rate, mode and enable fields together with one write strobe. It reads the flag through a read strobe, and that read also clears the flag.

Top module: `piv_periodic_div`

## Requirements
- R1: After synchronous reset: pflag=0, irq_n=1, the rate field is 0, the mode field is 000 (hold), the enable is 0 and the chain count is zero.
- R2: With rate code 0, pflag never sets in any mode.
- R3: In run mode (mode 010), rate codes 3 to 15 set pflag every 2^(code-1) time-base pulses. Code 3 gives 4 pulses (8.192 kHz) and code 15 gives 16384 pulses (2 Hz).
- R4: In run mode, rate code 1 sets pflag every 128 pulses (256 Hz) and rate code 2 every 256 pulses (128 Hz).
- R5: Modes 000, 001, 011, 110 and 111 hold the chain count at zero, and in these modes pflag never sets.
- R6: Modes 100 and 101 are test mode. In test mode, with a nonzero rate, every time-base pulse sets pflag in the cycle after the pulse.
- R7: When the chain leaves a hold mode for run mode, the first flag arrives exactly one full period, in pulses, after the release.
- R8: A flag fires on the pulse at which the count of pulses since release becomes a multiple of the period of the rate in force. A rate change therefore takes effect at the next such multiple of the new period, with no extra flag.
- R9: A flag_rd strobe clears pflag. If a flag event happens in the same cycle as the read, the flag stays set.
- R10: irq_n is low exactly when pflag=1 and the enable is 1. With the enable at 0, pflag still sets and irq_n stays high.
- R11: pflag rises only in the cycle after a tick_en pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle pulse at 32.768 kHz |
| cfg_we | input | 1 | Write strobe for rate, mode and enable |
| cfg_rate | input | 4 | Rate code |
| cfg_mode | input | 3 | Chain mode code |
| cfg_pie | input | 1 | Periodic interrupt enable |
| flag_rd | input | 1 | Flag read strobe; clears the flag |
| pflag | output | 1 | Periodic flag |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The assertions assume that tick_en is a single-cycle pulse. They also assume that the configuration fields are stable except in a cycle with cfg_we high. The bench drives tick_en for one cycle and then leaves it low for at least one cycle. It changes the configuration only through single write cycles placed between pulses, so no write lands on a pulse edge. Periods are measured by counting pulses from a hold-mode release, which gives every measurement a known zero point for the chain.

// File: rtl/piv_pkg.sv
package piv_pkg;
    localparam int RATE_W  = 4;
    localparam int MODE_W  = 3;
    localparam int CHAIN_W = (1 << RATE_W) - 2;
    localparam int EXP_W   = $clog2(CHAIN_W + 1);

    typedef enum logic [1:0] {
        CHAIN_HOLD = 2'd0,
        CHAIN_RUN  = 2'd1,
        CHAIN_TEST = 2'd2
    } chain_mode_e;

    typedef struct packed {
        logic [RATE_W-1:0] rate;
        logic [MODE_W-1:0] mode;
        logic              pie;
    } piv_cfg_t;

    // Mode decode: 010 run, 10x test, everything else holds the chain.
    function automatic chain_mode_e decode_mode(input logic [MODE_W-1:0] m);
        if (m == 3'b010)       return CHAIN_RUN;
        else if (m[2:1] == 2'b10) return CHAIN_TEST;
        else                   return CHAIN_HOLD;
    endfunction

    // Log2 of the period in time-base pulses for a rate code.
    function automatic logic [EXP_W-1:0] rate_exp(input logic [RATE_W-1:0] r);
        logic [EXP_W-1:0] e;
        case (r)
            4'd0:    e = '0;
            4'd1:    e = EXP_W'(7);
            4'd2:    e = EXP_W'(8);
            default: e = EXP_W'(r - 4'd1);
        endcase
        return e;
    endfunction
endpackage

// File: rtl/piv_cfg_regs.sv
module piv_cfg_regs
    import piv_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     we,
    input  piv_cfg_t wdata,
    output piv_cfg_t cfg_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (we) begin
            cfg_q <= wdata;
        end
    end
endmodule

// File: rtl/piv_div_chain.sv
module piv_div_chain
    import piv_pkg::*;
#(
    parameter int WIDTH = CHAIN_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  chain_mode_e      mode,
    output logic [WIDTH-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || mode == CHAIN_HOLD) begin
            cnt <= '0;
        end else if (tick_en) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/piv_rate_tap.sv
module piv_rate_tap
    import piv_pkg::*;
#(
    parameter int WIDTH = CHAIN_W
) (
    input  logic              tick_en,
    input  chain_mode_e       mode,
    input  logic [RATE_W-1:0] rate,
    input  logic [WIDTH-1:0]  cnt,
    output logic              hit
);
    localparam int TAPS = WIDTH + 1;

    logic [TAPS-1:0]  low_ones;
    logic [EXP_W-1:0] sel;

    assign low_ones[0] = 1'b1;
    for (genvar k = 1; k < TAPS; k++) begin : g_tap
        assign low_ones[k] = &cnt[k-1:0];
    end

    assign sel = rate_exp(rate);

    always_comb begin
        hit = 1'b0;
        if (rate != '0) begin
            case (mode)
                CHAIN_RUN:  hit = tick_en & low_ones[sel];
                CHAIN_TEST: hit = tick_en;
                default:    hit = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/piv_flag_irq.sv
module piv_flag_irq (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic rd,
    input  logic pie,
    output logic flag,
    output logic irq_n
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (set_evt) begin
            flag <= 1'b1;
        end else if (rd) begin
            flag <= 1'b0;
        end
    end

    assign irq_n = ~(flag & pie);
endmodule

// File: rtl/piv_periodic_div.sv
module piv_periodic_div
    import piv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              cfg_we,
    input  logic [RATE_W-1:0] cfg_rate,
    input  logic [MODE_W-1:0] cfg_mode,
    input  logic              cfg_pie,
    input  logic              flag_rd,
    output logic              pflag,
    output logic              irq_n
);
    piv_cfg_t            wr_cfg;
    piv_cfg_t            cfg_q;
    chain_mode_e         mode_dec;
    logic [CHAIN_W-1:0]  chain_cnt;
    logic                set_evt;
    logic [RATE_W-1:0]   rate_q;
    logic [MODE_W-1:0]   mode_q;
    logic                pie_q;

    assign wr_cfg = '{rate: cfg_rate, mode: cfg_mode, pie: cfg_pie};
    assign rate_q = cfg_q.rate;
    assign mode_q = cfg_q.mode;
    assign pie_q  = cfg_q.pie;
    assign mode_dec = decode_mode(mode_q);

    piv_cfg_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (wr_cfg),
        .cfg_q (cfg_q)
    );

    piv_div_chain #(.WIDTH(CHAIN_W)) u_chain (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .mode    (mode_dec),
        .cnt     (chain_cnt)
    );

    piv_rate_tap #(.WIDTH(CHAIN_W)) u_tap (
        .tick_en (tick_en),
        .mode    (mode_dec),
        .rate    (rate_q),
        .cnt     (chain_cnt),
        .hit     (set_evt)
    );

    piv_flag_irq u_flag (
        .clk     (clk),
        .rst     (rst),
        .set_evt (set_evt),
        .rd      (flag_rd),
        .pie     (pie_q),
        .flag    (pflag),
        .irq_n   (irq_n)
    );
endmodule

// File: rtl/piv_checker.sv
module piv_checker
    import piv_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               tick_en,
    input logic               flag_rd,
    input logic               pflag,
    input logic               irq_n,
    input logic [RATE_W-1:0]  rate_q,
    input logic [MODE_W-1:0]  mode_q,
    input logic               pie_q,
    input logic [CHAIN_W-1:0] chain_cnt,
    input logic               set_evt
);
    // R2
    a_r2_rate_zero_quiet: assert property (@(posedge clk) disable iff (rst)
        (rate_q == '0 && !pflag) |=> !pflag);

    // R5
    a_r5_hold_zero: assert property (@(posedge clk) disable iff (rst)
        (decode_mode(mode_q) == CHAIN_HOLD) |=> (chain_cnt == '0));

    // R6
    a_r6_test_every_tick: assert property (@(posedge clk) disable iff (rst)
        (decode_mode(mode_q) == CHAIN_TEST && rate_q != '0 && tick_en) |=> pflag);

    // R9
    a_r9_read_clears: assert property (@(posedge clk) disable iff (rst)
        (flag_rd && !set_evt) |=> !pflag);

    // R10
    a_r10_masked: assert property (@(posedge clk) disable iff (rst)
        !pie_q |-> irq_n);

    // R11
    a_r11_rise_on_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(pflag) |-> $past(tick_en));
endmodule

bind piv_periodic_div piv_checker chk_i (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .flag_rd   (flag_rd),
    .pflag     (pflag),
    .irq_n     (irq_n),
    .rate_q    (rate_q),
    .mode_q    (mode_q),
    .pie_q     (pie_q),
    .chain_cnt (chain_cnt),
    .set_evt   (set_evt)
);

// File: tb/piv_periodic_div_tb_top.sv
module piv_periodic_div_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       tick_en, cfg_we, cfg_pie, flag_rd;
    logic [3:0] cfg_rate;
    logic [2:0] cfg_mode;
    logic       pflag, irq_n;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 0;

    always #2 clk = ~clk;

    piv_periodic_div dut_i (
        .clk(clk), .rst(rst), .tick_en(tick_en), .cfg_we(cfg_we),
        .cfg_rate(cfg_rate), .cfg_mode(cfg_mode), .cfg_pie(cfg_pie),
        .flag_rd(flag_rd), .pflag(pflag), .irq_n(irq_n)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: act=%0d cycles exp<150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [2:0] m, input logic [3:0] r, input logic p);
        @(negedge clk);
        cfg_we = 1; cfg_mode = m; cfg_rate = r; cfg_pie = p;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic tick();
        @(negedge clk);
        tick_en = 1;
        @(negedge clk);
        tick_en = 0;
    endtask

    task automatic read_flag();
        @(negedge clk);
        flag_rd = 1;
        @(negedge clk);
        flag_rd = 0;
    endtask

    function automatic int period_of(input int code);
        if (code == 1) return 128;
        if (code == 2) return 256;
        return 1 << (code - 1);
    endfunction

    // R3 R4 R7: release from hold and count pulses to the first flag
    task automatic t_period(input int code, input string req);
        int n = 0;
        write_cfg(3'b000, 4'(code), 1'b1);
        read_flag();
        write_cfg(3'b010, 4'(code), 1'b1);
        while (n < 20000 && !pflag) begin
            tick();
            n++;
        end
        check(n == period_of(code), req, n, period_of(code));
        read_flag();
        // steady repeat: a second full period
        n = 0;
        while (n < 20000 && !pflag) begin
            tick();
            n++;
        end
        check(n == period_of(code), req, n, period_of(code));
        read_flag();
    endtask

    task automatic t_reset_state();
        check(pflag == 0, "R1 pflag", pflag, 0);
        check(irq_n == 1, "R1 irq_n", irq_n, 1);
    endtask

    task automatic t_rate_zero();
        bit seen = 0;
        write_cfg(3'b010, 4'd0, 1'b1);
        for (int i = 0; i < 300; i++) begin tick(); if (pflag) seen = 1; end
        write_cfg(3'b100, 4'd0, 1'b1);
        for (int i = 0; i < 10; i++) begin tick(); if (pflag) seen = 1; end
        check(!seen, "R2 rate 0 no flag", seen, 0);
    endtask

    task automatic t_hold_modes();
        logic [2:0] holds [5] = '{3'b000, 3'b001, 3'b011, 3'b110, 3'b111};
        for (int h = 0; h < 5; h++) begin
            bit seen = 0;
            write_cfg(holds[h], 4'd3, 1'b1);
            read_flag();
            for (int i = 0; i < 20; i++) begin tick(); if (pflag) seen = 1; end
            check(!seen, "R5 hold mode no flag", seen, 0);
        end
        // chain was held at zero: release gives a full first period (R7)
        t_period(3, "R5 R7 release after hold");
    endtask

    task automatic t_test_mode();
        write_cfg(3'b100, 4'd15, 1'b1);
        read_flag();
        tick();
        check(pflag == 1, "R6 test 100 flag per tick", pflag, 1);
        read_flag();
        write_cfg(3'b101, 4'd9, 1'b1);
        tick();
        check(pflag == 1, "R6 test 101 flag per tick", pflag, 1);
        // R9: event and read in the same cycle, set wins
        @(negedge clk);
        tick_en = 1; flag_rd = 1;
        @(negedge clk);
        tick_en = 0; flag_rd = 0;
        check(pflag == 1, "R9 set wins over read", pflag, 1);
        read_flag();
        check(pflag == 0, "R9 read clears", pflag, 0);
        check(irq_n == 1, "R9 irq released", irq_n, 1);
    endtask

    task automatic t_rate_change();
        bit early = 0;
        write_cfg(3'b000, 4'd4, 1'b1);
        read_flag();
        write_cfg(3'b010, 4'd4, 1'b1);
        for (int i = 0; i < 5; i++) begin tick(); if (pflag) early = 1; end
        write_cfg(3'b010, 4'd3, 1'b1);
        tick(); if (pflag) early = 1;
        tick(); if (pflag) early = 1;
        check(!early, "R8 no extra flag", early, 0);
        tick();
        check(pflag == 1, "R8 flag at pulse 8", pflag, 1);
        read_flag();
    endtask

    task automatic t_mask();
        write_cfg(3'b100, 4'd3, 1'b0);
        read_flag();
        tick();
        check(pflag == 1, "R10 flag sets while masked", pflag, 1);
        check(irq_n == 1, "R10 irq masked", irq_n, 1);
        write_cfg(3'b100, 4'd3, 1'b1);
        check(irq_n == 0, "R10 irq asserted when enabled", irq_n, 0);
        read_flag();
        check(irq_n == 1, "R10 irq released on read", irq_n, 1);
    endtask

    initial begin
        rst = 1; tick_en = 0; cfg_we = 0; cfg_pie = 0; flag_rd = 0;
        cfg_rate = 0; cfg_mode = 0;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset_state();
        t_rate_zero();
        t_period(3, "R3 code 3");
        t_period(4, "R3 code 4");
        t_period(8, "R3 code 8");
        t_period(1, "R4 code 1");
        t_period(2, "R4 code 2");
        t_period(15, "R3 code 15");
        t_hold_modes();
        t_test_mode();
        t_rate_change();
        t_mask();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule